// File: doc/BRIEF.md
# Byte-Lane Controller for Asynchronous Static RAM

This block lets logic running on a synchronous clock read and write an external asynchronous static RAM of 16-bit words. The memory has a low byte lane and a high byte lane, and each lane has its own active-low enable. A requester offers an address, a write flag, a two-bit lane mask and write data through a valid/ready handshake. Every accepted request produces exactly one single-cycle response pulse. For reads, the response carries the word with the unselected lanes cleared.

On the memory side the controller drives the address, an active-low chip select, output enable, write enable and the two lane enables. It also drives a split data bus (data out, drive enable, data in) that a tri-state pad at the chip level can combine. Read access time, write pulse width, data setup ahead of the pulse and the bus turnaround gap are parameters counted in clock cycles. Output enable stays high for the whole of every write, so the write pulse never has to absorb the memory's driver turn-off time. Between requests the chip select stays high so that the memory idles in standby. A request whose mask is all zeros is answered without touching the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and in every idle cycle, the following hold: chip select, output enable, write enable and both lane enables are high, the data drive enable is low, req_ready is high and rsp_valid is low.
- R2: A read request with a nonzero mask is accepted on a clock edge where req_valid and req_ready are both high. For the next READ_CYC cycles the controller holds the accepted address on mem_addr, with chip select low, output enable low and write enable high. Mask bit 0 drives mem_be_n[0] low (bits 7:0) and mask bit 1 drives mem_be_n[1] low (bits 15:8).
- R3: In the cycle after the last read access cycle, rsp_valid is high for one cycle and the memory is deselected. rsp_rdata holds the data-in lanes sampled in the last access cycle for the selected lanes and zero for the unselected lanes.
- R4: A write request with a nonzero mask produces three phases. First come SETUP_CYC cycles with chip select low, write enable high and data driven. Then come WRITE_CYC cycles with write enable low. Then comes one recovery cycle with write enable high while chip select, the lanes and the data are still held, and in that cycle rsp_valid is high with rsp_rdata zero. Write enable only falls after a cycle with data driven and chip select low.
- R5: Output enable is high in every cycle where write enable is low or the data drive enable is high.
- R6: From the first setup cycle through the recovery cycle of a write, the address, the lane enables and the data out do not change.
- R7: A read response is followed by TURN_CYC deselected cycles with req_ready low. The data drive enable never rises within TURN_CYC cycles of the last cycle in which the memory drove the bus.
- R8: A request with mask 00 is accepted in one cycle and leaves every memory pin idle. rsp_valid follows in the next cycle with rsp_rdata zero, and req_ready stays high.
- R9: req_ready is high only while no memory cycle is in progress, and the memory is deselected whenever req_ready is high.
- R10: Write enable is low only while chip select is low and at least one lane enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane select; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane enables, active low; bit 0 low lane |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench builds the controller with a 10-bit address and with every timing count above its default: three read access cycles, two setup cycles, a two-cycle write pulse and a two-cycle turnaround. With these counts the timer has to hold a state across several cycles. They also give a write enable low across consecutive edges, where address and lane stability can be checked, and a turnaround gap long enough to expose an early drive. The narrow address keeps the memory model small, so random masked traffic keeps returning to locations that earlier partial writes have merged.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int NUM_LANES = 2;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = NUM_LANES * LANE_W;

    typedef logic [NUM_LANES-1:0] lane_mask_t;
    typedef logic [WORD_W-1:0]    word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

    typedef struct packed {
        lane_mask_t mask;
        word_t      wdata;
    } held_req_t;

    function automatic word_t lane_bits(lane_mask_t m);
        word_t w;
        for (int i = 0; i < NUM_LANES; i++) begin
            w[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return w;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture
    import sram_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       capture,
    input  lane_mask_t mask,
    input  word_t      dq_in,
    output word_t      rdata
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int READ_CYC  = 2,
    parameter int WRITE_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [NUM_LANES-1:0] req_mask,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [NUM_LANES-1:0] mem_be_n,
    output logic [WORD_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [WORD_W-1:0]    mem_dq_in
);

    localparam int MAX_A = (READ_CYC > WRITE_CYC) ? READ_CYC : WRITE_CYC;
    localparam int MAX_B = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] WRITE_LD = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

    ctrl_state_e       state_q, state_d;
    held_req_t         held_q;
    logic [ADDR_W-1:0] addr_q;
    logic              skip_q, skip_d;
    logic              accept, capture;
    logic              t_load, t_done;
    logic [CNT_W-1:0]  t_val;
    logic              chip_on;

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_lane_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (capture),
        .mask    (held_q.mask),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        skip_d  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mask == '0) begin
                        skip_d = 1'b1;
                    end else if (req_write) begin
                        state_d = ST_WR_SETUP;
                        t_load  = 1'b1;
                        t_val   = SETUP_LD;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        t_load  = 1'b1;
                        t_val   = READ_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (t_done) begin
                    capture = 1'b1;
                    state_d = ST_RD_CAPTURE;
                end
            end
            ST_RD_CAPTURE: begin
                state_d = ST_TURNAROUND;
                t_load  = 1'b1;
                t_val   = TURN_LD;
            end
            ST_TURNAROUND: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (t_done) begin
                    state_d = ST_WR_PULSE;
                    t_load  = 1'b1;
                    t_val   = WRITE_LD;
                end
            end
            ST_WR_PULSE: begin
                if (t_done) state_d = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            addr_q  <= '0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= skip_d;
            if (accept) begin
                addr_q       <= req_addr;
                held_q.mask  <= req_mask;
                held_q.wdata <= req_wdata;
            end
        end
    end

    assign chip_on = (state_q == ST_RD_ACCESS) || (state_q == ST_WR_SETUP) ||
                     (state_q == ST_WR_PULSE)  || (state_q == ST_WR_RECOVER);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_be
        assign mem_be_n[g] = !(chip_on && held_q.mask[g]);
    end

    assign mem_cs_n   = !chip_on;
    assign mem_oe_n   = (state_q != ST_RD_ACCESS);
    assign mem_we_n   = (state_q != ST_WR_PULSE);
    assign mem_dq_oe  = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE) ||
                        (state_q == ST_WR_RECOVER);
    assign mem_dq_out = held_q.wdata;
    assign mem_addr   = addr_q;
    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = (state_q == ST_RD_CAPTURE) || (state_q == ST_WR_RECOVER) || skip_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_cs_n,
    input logic                 mem_oe_n,
    input logic                 mem_we_n,
    input logic [NUM_LANES-1:0] mem_be_n,
    input logic [WORD_W-1:0]    mem_dq_out,
    input logic                 mem_dq_oe
);

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe || !mem_we_n) |-> mem_oe_n);

    assert_we_inside_window_R10: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && !(&mem_be_n)));

    assert_window_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_out)));

    assert_ready_deselected_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_dq_oe));

    assert_pulse_after_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(!mem_cs_n)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    import sram_lane_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 10;
    localparam int RDC   = 3;
    localparam int WRC   = 2;
    localparam int SUC   = 2;
    localparam int TAC   = 2;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic             req_ready;
    logic [AW-1:0]    req_addr;
    logic             req_write;
    lane_mask_t       req_mask;
    word_t            req_wdata;
    logic             rsp_valid;
    word_t            rsp_rdata;
    logic [AW-1:0]    mem_addr;
    logic             mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    lane_mask_t       mem_be_n;
    word_t            mem_dq_out;
    word_t            mem_dq_in;

    sram_lane_ctrl #(.ADDR_W(AW), .READ_CYC(RDC), .WRITE_CYC(WRC),
                     .SETUP_CYC(SUC), .TURN_CYC(TAC)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  errors = 0;
    int  checks = 0;
    bit  ended  = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Memory model: lanes follow the enables, unselected lanes read as garbage.
    word_t ram [DEPTH];
    word_t sb  [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = word_t'(i * 37 + 11);
            sb[i]  = word_t'(i * 37 + 11);
        end
    end

    always_comb begin
        mem_dq_in = 16'h5A5A;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                mem_dq_in[l*LANE_W +: LANE_W] = mem_be_n[l] ? 8'hEE : ram[mem_addr][l*LANE_W +: LANE_W];
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && !mem_cs_n && !mem_we_n) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (!mem_be_n[l]) ram[mem_addr][l*LANE_W +: LANE_W] <= mem_dq_out[l*LANE_W +: LANE_W];
            end
        end
    end

    // Reference timeline: kind 0 idle, 1 read, 2 write; ph counts cycles after accept.
    int            kind = 0;
    int            ph   = 0;
    bit            skip_pend = 1'b0;
    logic [AW-1:0] e_addr;
    lane_mask_t    e_mask;
    word_t         e_wdata, e_rdata;

    always @(posedge clk) begin
        if (rst) begin
            kind = 0; ph = 0; skip_pend = 1'b0;
        end else if (kind == 0) begin
            skip_pend = 1'b0;
            if (req_valid) begin
                if (req_mask == '0) begin
                    skip_pend = 1'b1;
                end else begin
                    kind    = req_write ? 2 : 1;
                    ph      = 1;
                    e_addr  = req_addr;
                    e_mask  = req_mask;
                    e_wdata = req_wdata;
                    if (req_write) begin
                        for (int l = 0; l < NUM_LANES; l++)
                            if (req_mask[l]) sb[req_addr][l*LANE_W +: LANE_W] = req_wdata[l*LANE_W +: LANE_W];
                    end else begin
                        e_rdata = sb[req_addr] & lane_bits(req_mask);
                    end
                end
            end
        end else begin
            skip_pend = 1'b0;
            ph++;
            if (kind == 1 && ph > RDC + 1 + TAC) kind = 0;
            if (kind == 2 && ph > SUC + WRC + 1) kind = 0;
        end
    end

    // Per-cycle comparison and pin-level monitors, away from the active edge.
    int            since_drive = 100;
    logic          prev_we_low = 1'b0;
    logic [AW-1:0] prev_addr;
    lane_mask_t    prev_be;

    always @(negedge clk) begin
        if (!rst) begin
            logic [4:0] pins, e_pins;
            bit e_rdy, e_rv, e_oe_d;
            word_t e_rd;
            string tag;
            pins  = {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n};
            e_rd  = '0;
            e_oe_d = 1'b0;
            e_rdy = 1'b0;
            e_rv  = 1'b0;
            if (kind == 0) begin
                e_pins = 5'b11111; e_rdy = 1'b1; e_rv = skip_pend;
                tag = skip_pend ? "R8" : "R1";
            end else if (kind == 1) begin
                if (ph <= RDC) begin
                    e_pins = {3'b001, ~e_mask}; tag = "R2";
                    check(mem_addr == e_addr, "R2 addr", 32'(mem_addr), 32'(e_addr));
                end else if (ph == RDC + 1) begin
                    e_pins = 5'b11111; e_rv = 1'b1; e_rd = e_rdata; tag = "R3";
                end else begin
                    e_pins = 5'b11111; tag = "R7";
                end
            end else begin
                e_oe_d = 1'b1; tag = "R4";
                e_pins = {2'b01, !(ph > SUC && ph <= SUC + WRC), ~e_mask};
                e_rv   = (ph == SUC + WRC + 1);
                check(mem_addr == e_addr, "R6 addr", 32'(mem_addr), 32'(e_addr));
                check(mem_dq_out == e_wdata, "R6 data", 32'(mem_dq_out), 32'(e_wdata));
            end
            check(pins == e_pins, {tag, " pins"}, 32'(pins), 32'(e_pins));
            check(mem_dq_oe == e_oe_d, {tag, " dq_oe"}, 32'(mem_dq_oe), 32'(e_oe_d));
            check(req_ready == e_rdy, "R9 ready", 32'(req_ready), 32'(e_rdy));
            check(rsp_valid == e_rv, {tag, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
            if (e_rv) check(rsp_rdata == e_rd, {tag, " rdata"}, 32'(rsp_rdata), 32'(e_rd));

            check(!(!mem_we_n && !mem_oe_n), "R5 we/oe", 32'(mem_oe_n), 32'(1));
            check(!(mem_dq_oe && !mem_oe_n && !mem_cs_n), "R5 contention", 32'(mem_oe_n), 32'(1));
            if (!mem_we_n)
                check(!mem_cs_n && !(&mem_be_n), "R10 window", 32'({mem_cs_n, mem_be_n}), 32'(0));
            if (!mem_we_n && prev_we_low)
                check(mem_addr == prev_addr && mem_be_n == prev_be, "R6 overlap",
                      32'({mem_addr, mem_be_n}), 32'({prev_addr, prev_be}));
            if (mem_dq_oe)
                check(since_drive > TAC, "R7 turnaround", 32'(since_drive), 32'(TAC + 1));

            since_drive = (!mem_cs_n && !mem_oe_n) ? 0 : since_drive + 1;
            prev_we_low = !mem_we_n;
            prev_addr   = mem_addr;
            prev_be     = mem_be_n;
        end
    end

    task automatic send(input logic [AW-1:0] a, input logic w, input lane_mask_t m,
                        input word_t d);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_mask  = m;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_mask = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 R3 R4: full word and single lanes
        send(10'd5, 1'b1, 2'b11, 16'h1234);
        send(10'd5, 1'b0, 2'b11, 16'h0);
        send(10'd5, 1'b0, 2'b01, 16'h0);
        send(10'd5, 1'b0, 2'b10, 16'h0);
        // partial write merges with the old high lane
        send(10'd5, 1'b1, 2'b01, 16'hBEEF);
        send(10'd5, 1'b0, 2'b11, 16'h0);
        send(10'd5, 1'b1, 2'b10, 16'hC3A0);
        send(10'd5, 1'b0, 2'b11, 16'h0);
        // address boundaries
        send(10'd0, 1'b1, 2'b10, 16'hC3C3);
        send(10'(DEPTH-1), 1'b1, 2'b11, 16'h0F0F);
        send(10'd0, 1'b0, 2'b11, 16'h0);
        send(10'(DEPTH-1), 1'b0, 2'b11, 16'h0);
        // R8: zero mask back to back, then read shows nothing was written
        send(10'd7, 1'b0, 2'b00, 16'h0);
        send(10'd7, 1'b1, 2'b00, 16'hFFFF);
        send(10'd7, 1'b1, 2'b00, 16'hFFFF);
        send(10'd7, 1'b0, 2'b11, 16'h0);
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
            end
            send(10'($urandom_range(0, 15) + (($urandom_range(0, 7) == 0) ? DEPTH - 16 : 0)),
                 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 16'($urandom));
        end
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=completion");
        finish_run();
    end

endmodule